// File: doc/BRIEF.md
# Partition RESET Vector Generator

This block turns an old and a new memory line into the two write-control vectors that a resistive cross-point memory needs: one vector for bits to be driven into the high-resistance state (RESET) and one for bits to be driven into the low-resistance state (SET). Only bits that change are written. The line is cut into independent 8-bit slices, and each slice feeds one 8-bit array.

When a slice holds a RESET high enough in its bit range, the block adds extra RESETs below it. Concurrent RESETs on one word-line split it into shorter segments, which lowers the voltage drop on that line. The added RESETs go on the upper bit of each lower 2-bit pair that has no RESET of its own. Where the stored value of such a bit must be 1, a compensating SET follows the RESET, so the array ends up holding the new line.

A one-cycle `start_i` begins a pass. The block then works through the slices, `LANES` slices per cycle. It raises `done_o` for one cycle at the end of the pass and keeps the vectors and totals until the next pass starts. The totals let a controller check the line against a budget of concurrent operations.

Top module: `prv_gen`

## Requirements
- R1: For every bit, the base RESET is old=1/new=0 and the base SET is old=0/new=1. An unchanged bit gets neither, unless R4 adds a RESET to it.
- R2: Slice k is bits [8k+7:8k] of the line. Each slice's vectors depend only on that slice's old and new bits.
- R3: A slice with no base RESET in bit positions 3..7 outputs exactly its base vectors.
- R4: Otherwise, let T be the pair (bits 2p+1, 2p) that holds the slice's highest base RESET. Every pair p below T that has no base RESET gets an added RESET on bit 2p+1.
- R5: An added RESET gets a SET on the same bit when that bit's new value is 1, and no SET when its new value is 0.
- R6: Pair T and the pairs above it keep their base vectors. Bit 2p of any pair is never changed.
- R7: For the whole line, applying RESET and then SET to the old line gives the new line: (old & ~rst) | set == new.
- R8: `rst_cnt_o` and `set_cnt_o` equal the number of ones in `rst_vec_o` and `set_vec_o` once `done_o` has been seen.
- R9: A `start_i` seen while idle makes `busy_o` high from the next cycle. `done_o` is high for exactly one cycle, SLICES/LANES cycles after the start edge, and `busy_o` drops at that same edge. A `start_i` seen while busy is ignored. The line inputs must be held while busy.
- R10: Vectors and totals do not change from `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass (taken only when idle) |
| old_line_i | input | SLICES*SLICE_W | Currently stored line |
| new_line_i | input | SLICES*SLICE_W | Line to be stored |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| rst_vec_o | output | SLICES*SLICE_W | RESET vector |
| set_vec_o | output | SLICES*SLICE_W | SET vector |
| rst_cnt_o | output | clog2(SLICES*SLICE_W+1) | Number of RESETs in the line |
| set_cnt_o | output | clog2(SLICES*SLICE_W+1) | Number of SETs in the line |

## Verification
The bench builds the block with SLICES=4 and LANES=2. A pass then takes two beats, so beat sequencing and the last-beat pulse are both exercised while runs stay short. With only four slices per line, every one of the 65536 per-slice combinations of keep-0, keep-1, reset and set across eight bits can be applied, each in some slice position. The RESET/SET rules, the pair boundaries and the threshold at bit 3 are therefore covered in full. Directed passes add the timing of the handshake, a start issued while busy, and holding of the results.

// File: rtl/prv_pkg.sv
package prv_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} prv_state_e;
endpackage

// File: rtl/prv_slice.sv
module prv_slice #(
  parameter int SLICE_W = 8,
  parameter int HI_MIN  = 3
) (
  input  logic [SLICE_W-1:0] old_i,
  input  logic [SLICE_W-1:0] new_i,
  output logic [SLICE_W-1:0] rst_o,
  output logic [SLICE_W-1:0] set_o
);
  localparam int PAIRS = SLICE_W / 2;

  logic [SLICE_W-1:0] rst_raw, set_raw;
  logic [PAIRS-1:0]   below, hole, add;
  logic               trig;

  assign rst_raw = old_i & ~new_i;
  assign set_raw = ~old_i & new_i;
  assign trig    = |rst_raw[SLICE_W-1:HI_MIN];

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    // pair lies strictly below the pair holding the top reset
    if (p == PAIRS-1) begin : g_top
      assign below[p] = 1'b0;
    end else begin : g_low
      assign below[p] = |rst_raw[SLICE_W-1:2*p+2];
    end
    assign hole[p] = ~(rst_raw[2*p] | rst_raw[2*p+1]);
    assign add[p]  = trig & below[p] & hole[p];
    assign rst_o[2*p]   = rst_raw[2*p];
    assign rst_o[2*p+1] = rst_raw[2*p+1] | add[p];
    assign set_o[2*p]   = set_raw[2*p];
    assign set_o[2*p+1] = set_raw[2*p+1] | (add[p] & new_i[2*p+1]);
  end

  always_comb begin
    a_r7_data_restored: assert (((old_i & ~rst_o) | set_o) == new_i);
  end
endmodule

// File: rtl/prv_popcnt.sv
module prv_popcnt #(
  parameter int W     = 64,
  parameter int OUT_W = $clog2(W+1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [OUT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + OUT_W'(vec_i[i]);
  end
endmodule

// File: rtl/prv_gen.sv
module prv_gen
  import prv_pkg::*;
#(
  parameter int SLICES  = 64,
  parameter int LANES   = 8,
  parameter int SLICE_W = 8,
  parameter int HI_MIN  = 3,
  localparam int LINE_W = SLICES * SLICE_W,
  localparam int CNT_W  = $clog2(LINE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LINE_W-1:0] old_line_i,
  input  logic [LINE_W-1:0] new_line_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LINE_W-1:0] rst_vec_o,
  output logic [LINE_W-1:0] set_vec_o,
  output logic [CNT_W-1:0]  rst_cnt_o,
  output logic [CNT_W-1:0]  set_cnt_o
);
  localparam int BEATS  = SLICES / LANES;
  localparam int BEAT_W = LANES * SLICE_W;
  localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int PC_W   = $clog2(BEAT_W + 1);

  prv_state_e        state_q;
  logic [BW-1:0]     beat_q;
  logic              done_q;
  logic [LINE_W-1:0] rst_vec_q, set_vec_q;
  logic [CNT_W-1:0]  rst_cnt_q, set_cnt_q;

  logic [BEAT_W-1:0] beat_old, beat_new, beat_rst, beat_set;
  logic [PC_W-1:0]   pc_rst, pc_set;
  logic              last_beat;

  assign beat_old  = old_line_i[int'(beat_q)*BEAT_W +: BEAT_W];
  assign beat_new  = new_line_i[int'(beat_q)*BEAT_W +: BEAT_W];
  assign last_beat = (beat_q == BW'(BEATS-1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    prv_slice #(.SLICE_W(SLICE_W), .HI_MIN(HI_MIN)) i_slice (
      .old_i (beat_old[l*SLICE_W +: SLICE_W]),
      .new_i (beat_new[l*SLICE_W +: SLICE_W]),
      .rst_o (beat_rst[l*SLICE_W +: SLICE_W]),
      .set_o (beat_set[l*SLICE_W +: SLICE_W])
    );
  end

  prv_popcnt #(.W(BEAT_W), .OUT_W(PC_W)) i_pc_rst (.vec_i(beat_rst), .cnt_o(pc_rst));
  prv_popcnt #(.W(BEAT_W), .OUT_W(PC_W)) i_pc_set (.vec_i(beat_set), .cnt_o(pc_set));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      done_q    <= 1'b0;
      rst_vec_q <= '0;
      set_vec_q <= '0;
      rst_cnt_q <= '0;
      set_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_RUN;
          beat_q    <= '0;
          rst_vec_q <= '0;
          set_vec_q <= '0;
          rst_cnt_q <= '0;
          set_cnt_q <= '0;
        end
        ST_RUN: begin
          rst_vec_q[int'(beat_q)*BEAT_W +: BEAT_W] <= beat_rst;
          set_vec_q[int'(beat_q)*BEAT_W +: BEAT_W] <= beat_set;
          rst_cnt_q <= rst_cnt_q + CNT_W'(pc_rst);
          set_cnt_q <= set_cnt_q + CNT_W'(pc_set);
          if (last_beat) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = done_q;
  assign rst_vec_o = rst_vec_q;
  assign set_vec_o = set_vec_q;
  assign rst_cnt_o = rst_cnt_q;
  assign set_cnt_o = set_cnt_q;

  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(rst_vec_o) && $stable(set_vec_o)
                               && $stable(rst_cnt_o) && $stable(set_cnt_o)));
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_cnt_o <= CNT_W'(LINE_W)) && (set_cnt_o <= CNT_W'(LINE_W)));
endmodule

// File: tb/test_prv_gen.sv
module test_prv_gen;
  localparam int SLICES = 4;
  localparam int LANES  = 2;
  localparam int LW     = SLICES * 8;
  localparam int CW     = $clog2(LW + 1);
  localparam int BEATS  = SLICES / LANES;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] old_l = '0, new_l = '0;
  logic busy, done;
  logic [LW-1:0] rst_v, set_v;
  logic [CW-1:0] rst_c, set_c;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  prv_gen #(.SLICES(SLICES), .LANES(LANES)) i_prv_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .old_line_i(old_l), .new_line_i(new_l),
    .busy_o(busy), .done_o(done),
    .rst_vec_o(rst_v), .set_vec_o(set_v),
    .rst_cnt_o(rst_c), .set_cnt_o(set_c)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_slice(input logic [7:0] o, input logic [7:0] n,
                                    output logic [7:0] r, output logic [7:0] s);
    int hi = -1;
    r = o & ~n;
    s = ~o & n;
    for (int i = 0; i < 8; i++) if (r[i]) hi = i;
    if (hi >= 3)
      for (int p = 0; p < hi / 2; p++)
        if (!r[2*p] && !r[2*p+1]) begin
          r[2*p+1] = 1'b1;
          if (n[2*p+1]) s[2*p+1] = 1'b1;
        end
  endfunction

  task automatic run(input logic [LW-1:0] o, input logic [LW-1:0] n, output int lat);
    @(negedge clk);
    old_l = o; new_l = n; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
  endtask

  task automatic sweep_check(input logic [LW-1:0] o, input logic [LW-1:0] n);
    logic [LW-1:0] er, es;
    logic [7:0] r8, s8;
    int lat;
    for (int k = 0; k < SLICES; k++) begin
      ref_slice(o[k*8 +: 8], n[k*8 +: 8], r8, s8);
      er[k*8 +: 8] = r8;
      es[k*8 +: 8] = s8;
    end
    run(o, n, lat);
    check("R1/R4 rst", 64'(rst_v), 64'(er));
    check("R1/R5 set", 64'(set_v), 64'(es));
    check("R7 integrity", 64'((o & ~rst_v) | set_v), 64'(n));
    check("R8 rst count", 64'(rst_c), 64'($countones(er)));
    check("R8 set count", 64'(set_c), 64'($countones(es)));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog expired actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [LW-1:0] o, n, hold_r, hold_s;
    repeat (2) @(negedge clk);
    // R9 reset state
    check("R9 reset busy", 64'(busy), 64'(0));
    check("R9 reset done", 64'(done), 64'(0));
    check("R10 reset vec", 64'({rst_v, set_v}), 64'(0));
    rst_n = 1'b1;

    // R4 R5 example: only reset on bit 7, rest unchanged 1
    run(32'h0000_00FF, 32'h0000_007F, lat);
    check("R9 latency", 64'(lat), 64'(BEATS));
    check("R9 busy low at done", 64'(busy), 64'(0));
    check("R4 example rst", 64'(rst_v), 64'h0000_00AA);
    check("R5 example set", 64'(set_v), 64'h0000_002A);
    // R5 added resets on bits whose new value is 0: no set
    run(32'h0000_0080, 32'h0000_0000, lat);
    check("R5 no set", 64'(set_v), 64'h0);
    check("R4 rst new0", 64'(rst_v), 64'h0000_00AA);
    // R3 resets only below bit 3
    run(32'h0000_00FF, 32'h0000_00F8, lat);
    check("R3 low resets", 64'({rst_v, set_v}), {32'h0000_0007, 32'h0});
    // R6 top pair and above untouched
    run(32'h0000_00D0, 32'h0000_00C0, lat);
    check("R6 above top pair", 64'({rst_v, set_v}), {32'h0000_001A, 32'h0});
    // R2 slice 3 only
    run(32'hFF00_0000, 32'h7F00_0000, lat);
    check("R2 slice3 rst", 64'(rst_v), 64'hAA00_0000);
    check("R2 slice3 set", 64'(set_v), 64'h2A00_0000);

    // R9 start while busy ignored
    @(negedge clk);
    old_l = 32'h0000_00FF; new_l = 32'h0; start = 1'b1;
    @(posedge clk); @(negedge clk);
    lat = 0;
    while (!done) begin
      @(posedge clk); @(negedge clk);
      lat++;
      start = 1'b0;
    end
    check("R9 latency with busy start", 64'(lat), 64'(BEATS));
    @(posedge clk); @(negedge clk);
    check("R9 busy start ignored", 64'(busy), 64'(0));
    check("R9 result", 64'(rst_v), 64'h0000_00FF);

    // R10 hold after done while inputs change
    hold_r = rst_v; hold_s = set_v;
    old_l = 32'h1234_5678; new_l = 32'h8765_4321;
    repeat (3) @(negedge clk);
    check("R10 hold", 64'({rst_v, set_v}), {hold_r, hold_s});

    // exhaustive per-slice sweep
    for (int it = 0; it < 16384; it++) begin
      for (int k = 0; k < SLICES; k++) begin
        logic [15:0] code;
        code = 16'(it * SLICES + k);
        for (int b = 0; b < 8; b++) begin
          case (code[2*b +: 2])
            2'd0: begin o[k*8+b] = 1'b0; n[k*8+b] = 1'b0; end
            2'd1: begin o[k*8+b] = 1'b1; n[k*8+b] = 1'b1; end
            2'd2: begin o[k*8+b] = 1'b1; n[k*8+b] = 1'b0; end
            default: begin o[k*8+b] = 1'b0; n[k*8+b] = 1'b1; end
          endcase
        end
      end
      sweep_check(o, n);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule